// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Flags

This block is the receive-side character queue of a serial port. A receiver writes each completed character into it together with three error flags: parity, framing and break. A host reads characters back in arrival order. The queue holds 64 characters by default. The entry at the head can be seen without read latency: the byte and its three flags both appear on the outputs.

The block also keeps a running count of stored characters whose flags are not all zero. From that count it drives a summary error flag. The flag stays high while any flagged character is still in the queue, and it drops only when the last such character is read out.

A write to a full queue loses the byte and sets a sticky overrun flag. A separate strobe clears that flag.

Top module: `rx_err_fifo`

## Requirements
- R1: After a synchronous active-low reset, empty=1, full=0, level=0, err_any=0, overrun=0 and head_flags=0.
- R2: Characters are read out in the order they were written, with no loss. rd_data shows the head byte in the same cycle, with no read latency. rd_data is 0 while the queue is empty.
- R3: level counts the stored characters. An accepted write raises it by one and an accepted read lowers it by one. A write and a read in the same cycle on a non-empty queue leave it unchanged. full is 1 exactly when level equals DEPTH, and empty is 1 exactly when level is 0.
- R4: head_flags is the flag triple of the character at the head: bit 0 is parity, bit 1 is framing and bit 2 is break. After a read, head_flags shows the flags of the new head from the next cycle on.
- R5: While the queue is empty, head_flags reads 3'b000.
- R6: err_any is 1 whenever at least one stored character has a non-zero flag triple.
- R7: err_any goes low only in the cycle after the last stored flagged character is read. This holds when a read and a write happen in the same cycle.
- R8: A write while full is dropped. Level and stored contents stay unchanged, and overrun is set.
- R9: overrun stays high until ovr_clr is pulsed. If an overrun and ovr_clr occur in the same cycle, overrun is set.
- R10: A read on an empty queue has no effect. level stays 0 and err_any stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write a character this cycle |
| wr_data | input | 8 | Character byte to write |
| wr_flags | input | 3 | Error flags of the written character: {break, framing, parity} |
| rd_en | input | 1 | Pop the head character this cycle |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 8 | Byte at the head |
| head_flags | output | 3 | Error flags of the head character, 0 when empty |
| err_any | output | 1 | Some stored character carries an error |
| level | output | 7 | Number of stored characters |
| empty | output | 1 | Queue holds no character |
| full | output | 1 | Queue holds DEPTH characters |
| overrun | output | 1 | Sticky flag: a write was lost to a full queue |

## Verification
The bench interleaves clean and flagged characters and checks head_flags after every read. A design that latched the flags at write time, or that lagged them by one read, would show the wrong triple. Several flagged entries are queued so that err_any must stay high until the last of them leaves. A simple set/clear flag would drop err_any after the first flagged read.

A full queue receives an extra write, and the bench then drains every entry. This shows whether the dropped byte overwrote the oldest entry or wrapped a pointer. Same-cycle read-and-write on flagged data, a read of an empty queue, and an overrun that coincides with ovr_clr each target a counting or priority slip.

// File: rtl/rxq_pkg.sv
// Shared types for the receive queue.
// Assumes the receiver delivers 8-bit characters with three error flags.
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;   // bit0 parity, bit1 framing, bit2 break

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Circular storage with read/write pointers and an occupancy count.
// Assumes push and pop are already qualified (no push when full, no pop when
// empty). The head entry is read combinationally from the array.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t wr_entry,
    output rxq_entry_t head_entry,
    output logic [LW-1:0] level,
    output logic       empty,
    output logic       full
);
    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_entry;
    end

    // Advance the pointers on qualified push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
        end
    end

    // Track occupancy; a simultaneous push and pop cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (push && !pop) begin
            level <= level + LW'(1);
        end else if (pop && !push) begin
            level <= level - LW'(1);
        end
    end

    assign head_entry = mem[rd_ptr];
    assign empty      = (level == '0);
    assign full       = (level == LW'(DEPTH));
endmodule

// File: rtl/rxq_errcount.sv
// Counts stored entries whose flag triple is non-zero.
// Assumes inc and dec come from qualified pushes and pops.
module rxq_errcount #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt
);
    // Add arriving flagged entries and remove departing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(inc) - CW'(dec);
    end
endmodule

// File: rtl/rx_err_fifo.sv
// Receive queue that keeps each character's parity/framing/break flags.
// It shows the head entry and its flags, and raises a summary error flag
// while any flagged entry is stored. A write to a full queue is dropped and
// sets a sticky overrun flag. A read of an empty queue does nothing.
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              rd_en,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAG_W-1:0] head_flags,
    output logic              err_any,
    output logic [LW-1:0]     level,
    output logic              empty,
    output logic              full,
    output logic              overrun
);
    rxq_entry_t wr_entry;
    rxq_entry_t head_entry;
    logic       push_ok;
    logic       pop_ok;
    logic [LW-1:0] err_cnt;

    assign push_ok  = wr_en && !full;
    assign pop_ok   = rd_en && !empty;
    assign wr_entry = '{flags: wr_flags, data: wr_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_ok),
        .pop        (pop_ok),
        .wr_entry   (wr_entry),
        .head_entry (head_entry),
        .level      (level),
        .empty      (empty),
        .full       (full)
    );

    rxq_errcount #(.CW(LW)) u_errcount (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (push_ok && (wr_flags != '0)),
        .dec   (pop_ok && (head_entry.flags != '0)),
        .cnt   (err_cnt)
    );

    // Head view is forced to zero while nothing is stored.
    assign rd_data    = empty ? '0 : head_entry.data;
    assign head_flags = empty ? '0 : head_entry.flags;
    assign err_any    = (err_cnt != '0);

    // Sticky overrun: a lost write wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                overrun <= 1'b0;
        else if (wr_en && full)    overrun <= 1'b1;
        else if (ovr_clr)          overrun <= 1'b0;
    end

    // R3: a lone accepted write raises the level by one.
    a_r3_level_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !rd_en) |=> (level == $past(level) + LW'(1)));

    // R6: the summary flag implies something is stored.
    a_r6_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> !empty);

    // R7: flagged count never exceeds the occupancy.
    a_r7_cnt_within_level: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= level);

    // R7: the summary flag drops only after a read.
    a_r7_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_any) |-> $past(rd_en));

    // R8: a write into a full queue with no read keeps it full.
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && overrun));

    // R9: overrun holds without a clear.
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R10: reading an empty queue leaves it empty.
    a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && !err_any));
endmodule

// File: tb/test_rx_err_fifo.sv
// Directed bench for rx_err_fifo, one task per scenario, with a queue model.
module test_rx_err_fifo;
    localparam int CLK_P = 10;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_flags = '0;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] head_flags;
    logic       err_any;
    logic [6:0] level;
    logic       empty;
    logic       full;
    logic       overrun;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [10:0] mq [$];   // {flags, data}
    bit m_ovr = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_err_fifo #(.DEPTH(DEPTH)) i_rx_err_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_flags(wr_flags), .rd_en(rd_en), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .head_flags(head_flags), .err_any(err_any),
        .level(level), .empty(empty), .full(full), .overrun(overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_err();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    // Compare every output with the model.
    task automatic check_all(input string where);
        int n = mq.size();
        check({"R3 level ", where}, level, n);
        check({"R3 empty ", where}, empty, n == 0);
        check({"R3 full ", where}, full, n == DEPTH);
        check({"R2 data ", where}, rd_data, n == 0 ? 0 : mq[0][7:0]);
        check({"R4 flags ", where}, head_flags, n == 0 ? 0 : mq[0][10:8]);
        check({"R6 err_any ", where}, err_any, model_err());
        check({"R9 overrun ", where}, overrun, m_ovr);
    endtask

    // One clock with the given inputs; updates the model and samples after the edge.
    task automatic step(input bit w, input logic [7:0] d, input logic [2:0] f,
                        input bit r, input bit c);
        bit pop_ok = r && mq.size() > 0;
        bit push_ok = w && mq.size() < DEPTH;
        wr_en = w; wr_data = d; wr_flags = f; rd_en = r; ovr_clr = c;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
        if (w && !push_ok) m_ovr = 1'b1;
        else if (c) m_ovr = 1'b0;
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back({f, d});
    endtask

    task automatic t_reset();
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 level", level, 0);
        check("R1 err_any", err_any, 0);
        check("R1 overrun", overrun, 0);
        check("R5 flags at reset", head_flags, 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) begin
            step(1, 8'h30 + 8'(i), 3'b000, 0, 0);
            check_all("order push");
        end
        for (int i = 0; i < 5; i++) begin
            check("R2 order", rd_data, 32'h30 + i);
            step(0, 0, 0, 1, 0);
            check_all("order pop");
        end
        check("R5 flags empty", head_flags, 0);
    endtask

    task automatic t_flags();
        step(1, 8'hA1, 3'b001, 0, 0);
        step(1, 8'hA2, 3'b000, 0, 0);
        step(1, 8'hA3, 3'b010, 0, 0);
        step(1, 8'hA4, 3'b100, 0, 0);
        step(1, 8'hA5, 3'b000, 0, 0);
        check("R4 head parity", head_flags, 3'b001);
        check_all("flags filled");
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0, 1, 0);
            check_all("flags pop");
        end
        check("R7 err_any after last flagged", err_any, 0);
    endtask

    task automatic t_last_err();
        step(1, 8'h11, 3'b010, 0, 0);
        step(1, 8'h12, 3'b110, 0, 0);
        step(1, 8'h13, 3'b000, 0, 0);
        step(0, 0, 0, 1, 0);
        check("R7 still set after first flagged read", err_any, 1);
        step(0, 0, 0, 1, 0);
        check("R7 clear after last flagged read", err_any, 0);
        check("R4 clean head", head_flags, 0);
        step(0, 0, 0, 1, 0);
        check_all("last_err");
    endtask

    task automatic t_simul();
        step(1, 8'h21, 3'b001, 0, 0);
        step(1, 8'h22, 3'b000, 1, 0);
        check("R3 level same on push+pop", level, 1);
        check("R7 flagged left with push+pop", err_any, 0);
        step(1, 8'h23, 3'b100, 1, 0);
        check("R6 flagged arrived with push+pop", err_any, 1);
        check_all("simul");
        step(0, 0, 0, 1, 0);
        check_all("simul drain");
    endtask

    task automatic t_empty_pop();
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        check("R10 level after empty read", level, 0);
        check("R10 err_any after empty read", err_any, 0);
        check("R10 empty after empty read", empty, 1);
        step(1, 8'h5A, 3'b000, 0, 0);
        check("R10 next byte intact", rd_data, 8'h5A);
        step(0, 0, 0, 1, 0);
    endtask

    task automatic t_full_overrun();
        for (int i = 0; i < DEPTH; i++)
            step(1, 8'(i), (i == 10) ? 3'b010 : 3'b000, 0, 0);
        check("R3 full at depth", full, 1);
        step(1, 8'hEE, 3'b111, 0, 0);
        check("R8 level held", level, DEPTH);
        check("R8 overrun set", overrun, 1);
        check("R8 head intact", rd_data, 0);
        step(0, 0, 0, 0, 0);
        check("R9 overrun held", overrun, 1);
        step(1, 8'hEF, 3'b000, 0, 1);
        check("R9 set wins over clear", overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 0, 1, 0);
            check_all("drain");
        end
        step(0, 0, 0, 0, 1);
        check("R9 cleared by strobe", overrun, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_flags();
        t_last_err();
        t_simul();
        t_empty_pop();
        t_full_overrun();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule